// File: doc/BRIEF.md
# Two-Level DMA Channel Arbiter

This block chooses which DMA channel is serviced next. The request lines are split into groups of sixteen channels, and there are one, two or four groups, set by a parameter. Arbitration happens in two steps. The first step picks one group that has at least one active request. The second step picks one requesting channel inside that group. Each step has its own mode bit that selects either fixed priority or round-robin, so the four combinations of modes can all be used.

In fixed-priority mode, the channel step uses a programmable priority value for each channel. The group step uses a two-bit priority value for each group. In round-robin mode, each step keeps a pointer and starts its search just past the last channel or group it served. The group step has one pointer. Each group has its own channel pointer. Two groups that share a priority value are a configuration error. An error flag is raised and no grant is issued while the fault remains.

The result leaves a register. It is a one-cycle valid flag and a 6-bit channel number. The number is built as group times sixteen plus the channel's position inside the group. The logic re-evaluates on every clock.

Top module: `dma_arb_top`

## Requirements
- R1: `NCH` may be 16, 32 or 64. Group g owns channels 16g to 16g+15. A grant reports `gnt_ch` = 16·group + local position, and this value is always below `NCH`.
- R2: The grant is registered. Requests sampled at one rising edge produce `gnt_vld` high for the following cycle. `gnt_vld` is low whenever no request was sampled.
- R3: With `ch_rr_mode`=0, the granted channel is the requesting channel in the chosen group with the largest value in `ch_prio` (field width `CH_PRIO_W` at bit offset ch·`CH_PRIO_W`). When two values are equal, the higher-numbered channel wins.
- R4: With `ch_rr_mode`=1, channel priorities are ignored. Each group searches upward, with wrap-around, from one past the local position it last granted. This pointer starts at 0 after reset and advances on every grant from that group.
- R5: With `grp_rr_mode`=0, the group chosen is the requesting group with the largest 2-bit field in `grp_prio` (group g at bits 2g+1:2g). Value 3 ranks highest and 0 lowest.
- R6: With `grp_rr_mode`=1, group priorities are ignored. The group search starts one past the last granted group, with wrap-around, and skips groups that have no request. The pointer starts at 0 after reset.
- R7: When any request is present and two implemented groups hold the same `grp_prio` value, `cfg_err` is high in the next cycle and `gnt_vld` is low. Duplicate values with no request present raise nothing.
- R8: `cfg_err` stays set until `err_clr` is sampled high or the group priorities become distinct. A 16-channel build has one group and never raises the error.
- R9: Every granted channel had its request line high at the edge that produced the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NCH | Per-channel service requests |
| ch_prio | input | NCH·CH_PRIO_W | Per-channel priority fields |
| grp_prio | input | 2·NCH/16 | Per-group 2-bit priority fields |
| ch_rr_mode | input | 1 | 1 = round-robin inside groups, 0 = fixed priority |
| grp_rr_mode | input | 1 | 1 = round-robin across groups, 0 = fixed priority |
| err_clr | input | 1 | Clears a latched configuration error |
| gnt_vld | output | 1 | Registered grant valid |
| gnt_ch | output | 6 | Granted channel number |
| cfg_err | output | 1 | Duplicate group priority flag |

## Verification
The bench builds two instances. One uses the default 64-channel build. The other uses a 16-channel build with a 4-bit channel priority field.

The 64-channel build has four groups, so group rotation can be tested with an idle group that must be skipped. It also lets group priority order be tested across distant channel numbers and duplicate priorities be checked among several groups.

The 16-channel build has a single group, which brings the case where the uniqueness check must stay silent within reach.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;
   localparam int GRP_CH     = 16;
   localparam int GRP_LW     = 4;
   localparam int CH_IDX_W   = 6;
   localparam int GRP_PRIO_W = 2;
endpackage

// File: rtl/dma_arb_rr_pick.sv
`timescale 1ns/1ps
module dma_arb_rr_pick #(
   parameter  int N  = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] start,
   output logic          hit,
   output logic [IW-1:0] idx
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int k = 0; k < N; k++) begin
         if (!hit && req[(int'(start) + k) % N]) begin
            hit = 1'b1;
            idx = IW'((int'(start) + k) % N);
         end
      end
   end
endmodule

// File: rtl/dma_arb_prio_pick.sv
`timescale 1ns/1ps
module dma_arb_prio_pick #(
   parameter  int N  = 16,
   parameter  int W  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]   req,
   input  logic [N*W-1:0] prio,
   output logic           hit,
   output logic [IW-1:0]  idx
);
   logic [W-1:0] best;

   // ascending scan with >= lets the higher index win a tie
   always_comb begin
      hit  = 1'b0;
      idx  = '0;
      best = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!hit || prio[i*W +: W] >= best)) begin
            hit  = 1'b1;
            idx  = IW'(i);
            best = prio[i*W +: W];
         end
      end
   end
endmodule

// File: rtl/dma_arb_cfg_chk.sv
`timescale 1ns/1ps
module dma_arb_cfg_chk #(
   parameter int NG = 4,
   parameter int W  = 2
) (
   input  logic [NG*W-1:0] prio,
   output logic            dup
);
   always_comb begin
      dup = 1'b0;
      for (int a = 0; a < NG; a++) begin
         for (int b = a + 1; b < NG; b++) begin
            if (prio[a*W +: W] == prio[b*W +: W]) dup = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dma_arb_top.sv
`timescale 1ns/1ps
module dma_arb_top
   import dma_arb_pkg::*;
#(
   parameter  int NCH       = 64,
   parameter  int CH_PRIO_W = 4,
   localparam int NGRP      = NCH / GRP_CH,
   localparam int GIW       = (NGRP > 1) ? $clog2(NGRP) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NCH-1:0]            req,
   input  logic [NCH*CH_PRIO_W-1:0]  ch_prio,
   input  logic [NGRP*GRP_PRIO_W-1:0] grp_prio,
   input  logic                      ch_rr_mode,
   input  logic                      grp_rr_mode,
   input  logic                      err_clr,
   output logic                      gnt_vld,
   output logic [CH_IDX_W-1:0]       gnt_ch,
   output logic                      cfg_err
);
   if (!(NCH == 16 || NCH == 32 || NCH == 64)) begin : g_bad_nch
      $error("dma_arb_top: NCH must be 16, 32 or 64");
   end
   if (CH_PRIO_W < 1 || CH_PRIO_W > 8) begin : g_bad_pw
      $error("dma_arb_top: CH_PRIO_W out of range");
   end

   logic [NGRP-1:0]             grp_req;
   logic [NGRP-1:0]             lane_hit;
   logic [NGRP-1:0][GRP_LW-1:0] lane_idx;
   logic [NGRP-1:0][GRP_LW-1:0] ch_ptr_q;
   logic [GIW-1:0]              grp_ptr_q;

   // channel level, one pair of pickers per group
   for (genvar g = 0; g < NGRP; g++) begin : g_lane
      logic              rr_hit, fx_hit;
      logic [GRP_LW-1:0] rr_idx, fx_idx;

      assign grp_req[g] = |req[g*GRP_CH +: GRP_CH];

      dma_arb_rr_pick #(.N(GRP_CH)) u_rr (
         .req   (req[g*GRP_CH +: GRP_CH]),
         .start (ch_ptr_q[g]),
         .hit   (rr_hit),
         .idx   (rr_idx)
      );

      dma_arb_prio_pick #(.N(GRP_CH), .W(CH_PRIO_W)) u_fx (
         .req  (req[g*GRP_CH +: GRP_CH]),
         .prio (ch_prio[g*GRP_CH*CH_PRIO_W +: GRP_CH*CH_PRIO_W]),
         .hit  (fx_hit),
         .idx  (fx_idx)
      );

      assign lane_hit[g] = ch_rr_mode ? rr_hit : fx_hit;
      assign lane_idx[g] = ch_rr_mode ? rr_idx : fx_idx;
   end

   // group level
   logic           grr_hit, gfx_hit, grp_hit;
   logic [GIW-1:0] grr_idx, gfx_idx, grp_sel;

   dma_arb_rr_pick #(.N(NGRP)) u_grp_rr (
      .req   (grp_req),
      .start (grp_ptr_q),
      .hit   (grr_hit),
      .idx   (grr_idx)
   );

   dma_arb_prio_pick #(.N(NGRP), .W(GRP_PRIO_W)) u_grp_fx (
      .req  (grp_req),
      .prio (grp_prio),
      .hit  (gfx_hit),
      .idx  (gfx_idx)
   );

   assign grp_hit = grp_rr_mode ? grr_hit : gfx_hit;
   assign grp_sel = grp_rr_mode ? grr_idx : gfx_idx;

   logic dup;
   dma_arb_cfg_chk #(.NG(NGRP), .W(GRP_PRIO_W)) u_cfg (
      .prio (grp_prio),
      .dup  (dup)
   );

   // mux the winning lane without a dynamic array index
   logic              sel_hit;
   logic [GRP_LW-1:0] sel_idx;
   always_comb begin
      sel_hit = 1'b0;
      sel_idx = '0;
      for (int g = 0; g < NGRP; g++) begin
         if (grp_sel == GIW'(g)) begin
            sel_hit = lane_hit[g];
            sel_idx = lane_idx[g];
         end
      end
   end

   logic                fire;
   logic [CH_IDX_W-1:0] gnt_d;
   logic [GIW-1:0]      grp_nxt;

   assign fire    = grp_hit && sel_hit && !dup;
   assign gnt_d   = (CH_IDX_W'(grp_sel) << GRP_LW) | CH_IDX_W'(sel_idx);
   assign grp_nxt = (int'(grp_sel) == NGRP - 1) ? '0 : grp_sel + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_vld   <= 1'b0;
         gnt_ch    <= '0;
         cfg_err   <= 1'b0;
         grp_ptr_q <= '0;
         ch_ptr_q  <= '0;
      end else begin
         gnt_vld <= fire;
         if (fire) begin
            gnt_ch    <= gnt_d;
            grp_ptr_q <= grp_nxt;
            for (int g = 0; g < NGRP; g++) begin
               if (grp_sel == GIW'(g)) ch_ptr_q[g] <= sel_idx + 1'b1;
            end
         end
         if (|req && dup)         cfg_err <= 1'b1;
         else if (err_clr || !dup) cfg_err <= 1'b0;
      end
   end
endmodule

// File: rtl/dma_arb_chk.sv
`timescale 1ns/1ps
module dma_arb_chk
   import dma_arb_pkg::*;
#(
   parameter  int NCH       = 64,
   parameter  int CH_PRIO_W = 4,
   localparam int NGRP      = NCH / GRP_CH
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NCH-1:0]              req,
   input logic [NCH*CH_PRIO_W-1:0]    ch_prio,
   input logic [NGRP*GRP_PRIO_W-1:0]  grp_prio,
   input logic                        ch_rr_mode,
   input logic                        grp_rr_mode,
   input logic                        gnt_vld,
   input logic [CH_IDX_W-1:0]         gnt_ch,
   input logic                        cfg_err
);
   logic [NCH-1:0]              req_d;
   logic [NCH*CH_PRIO_W-1:0]    cprio_d;
   logic [NGRP*GRP_PRIO_W-1:0]  gprio_d;
   logic                        chrr_d, grr_d;

   always_ff @(posedge clk) begin
      req_d   <= req;
      cprio_d <= ch_prio;
      gprio_d <= grp_prio;
      chrr_d  <= ch_rr_mode;
      grr_d   <= grp_rr_mode;
   end

   logic was_req, ch_ok, grp_ok;
   always_comb begin
      was_req = 1'b0;
      ch_ok   = 1'b1;
      grp_ok  = 1'b1;
      for (int c = 0; c < NCH; c++) begin
         if (int'(gnt_ch) == c) was_req = req_d[c];
         if ((c / GRP_CH) == int'(gnt_ch) / GRP_CH && int'(gnt_ch) < NCH && req_d[c]) begin
            if (cprio_d[c*CH_PRIO_W +: CH_PRIO_W] > cprio_d[int'(gnt_ch)*CH_PRIO_W +: CH_PRIO_W])
               ch_ok = 1'b0;
            if (cprio_d[c*CH_PRIO_W +: CH_PRIO_W] == cprio_d[int'(gnt_ch)*CH_PRIO_W +: CH_PRIO_W]
                && c > int'(gnt_ch))
               ch_ok = 1'b0;
         end
      end
      for (int g = 0; g < NGRP; g++) begin
         if (|req_d[g*GRP_CH +: GRP_CH] && int'(gnt_ch) < NCH &&
             gprio_d[g*GRP_PRIO_W +: GRP_PRIO_W] >
             gprio_d[(int'(gnt_ch) / GRP_CH)*GRP_PRIO_W +: GRP_PRIO_W])
            grp_ok = 1'b0;
      end
   end

   assert_gnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> int'(gnt_ch) < NCH);
   assert_idle_no_gnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_d) |-> !gnt_vld);
   assert_fixed_ch_best_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld && !chrr_d) |-> ch_ok);
   assert_fixed_grp_best_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld && !grr_d) |-> grp_ok);
   assert_err_blocks_gnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !gnt_vld);
   assert_gnt_was_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> was_req);
endmodule

bind dma_arb_top dma_arb_chk #(.NCH(NCH), .CH_PRIO_W(CH_PRIO_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req         (req),
   .ch_prio     (ch_prio),
   .grp_prio    (grp_prio),
   .ch_rr_mode  (ch_rr_mode),
   .grp_rr_mode (grp_rr_mode),
   .gnt_vld     (gnt_vld),
   .gnt_ch      (gnt_ch),
   .cfg_err     (cfg_err)
);

// File: tb/dma_arb_top_test.sv
`timescale 1ns/1ps
module dma_arb_top_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [63:0]  req = '0;
   logic [255:0] cprio = '0;
   logic [7:0]   gprio = 8'b11_10_01_00;
   logic         ch_rr = 1'b0, grp_rr = 1'b0, eclr = 1'b0;
   logic         vld, err;
   logic [5:0]   ch;

   logic [15:0]  req16 = '0;
   logic [63:0]  cprio16 = '0;
   logic [1:0]   gprio16 = 2'b00;
   logic         vld16, err16;
   logic [5:0]   ch16;

   dma_arb_top #(.NCH(64), .CH_PRIO_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .ch_prio(cprio), .grp_prio(gprio),
      .ch_rr_mode(ch_rr), .grp_rr_mode(grp_rr), .err_clr(eclr),
      .gnt_vld(vld), .gnt_ch(ch), .cfg_err(err));

   dma_arb_top #(.NCH(16), .CH_PRIO_W(4)) uut16 (
      .clk(clk), .rst_n(rst_n), .req(req16), .ch_prio(cprio16), .grp_prio(gprio16),
      .ch_rr_mode(1'b0), .grp_rr_mode(1'b0), .err_clr(1'b0),
      .gnt_vld(vld16), .gnt_ch(ch16), .cfg_err(err16));

   int total = 0, bad = 0;
   bit done = 0;

   task automatic chk(input string rq, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic setp(input int c, input int v);
      cprio[c*4 +: 4] = 4'(v);
   endtask

   task automatic chk_gnt(input string rq, input int exp_ch);
      chk({rq, " valid"}, int'(vld), 1);
      chk({rq, " channel"}, int'(ch), exp_ch);
   endtask

   task automatic t_reset();
      chk("R2 reset valid", int'(vld), 0);
      chk("R7 reset error", int'(err), 0);
      req = '0; step();
      chk("R2 idle no grant", int'(vld), 0);
   endtask

   task automatic t_fixed();
      ch_rr = 0; grp_rr = 0; gprio = 8'b11_10_01_00;
      setp(5, 3); setp(9, 7);
      req = '0; req[5] = 1; req[9] = 1; step();
      chk_gnt("R3 highest prio", 9);
      setp(2, 5); setp(4, 5);
      req = '0; req[2] = 1; req[4] = 1; step();
      chk_gnt("R3 tie to higher", 4);
      req = '0; req[3] = 1; req[50] = 1; step();
      chk_gnt("R5 group 3 first", 50);
      gprio = 8'b00_01_10_11; step();
      chk_gnt("R5 group 0 first", 3);
      gprio = 8'b11_10_01_00;
      req = '0; req[37] = 1; step();
      chk_gnt("R1 mapping", 37);
      req = '0; step();
      chk("R2 drop to idle", int'(vld), 0);
   endtask

   task automatic t_ch_rr();
      ch_rr = 1; grp_rr = 0;
      setp(12, 15);
      req = '0; req[15] = 1; step();
      chk_gnt("R4 preset", 15);
      req = '0; req[1] = 1; req[7] = 1; req[12] = 1;
      step(); chk_gnt("R4 rot a", 1);
      step(); chk_gnt("R4 rot b", 7);
      step(); chk_gnt("R4 rot c", 12);
      step(); chk_gnt("R4 wrap", 1);
      req = '0; step();
   endtask

   task automatic t_grp_rr();
      ch_rr = 0; grp_rr = 1;
      req = '0; req[48] = 1; step();
      chk_gnt("R6 preset", 48);
      req = '0; req[5] = 1; req[40] = 1; req[60] = 1;
      step(); chk_gnt("R6 rot a", 5);
      step(); chk_gnt("R6 skip idle", 40);
      step(); chk_gnt("R6 rot c", 60);
      step(); chk_gnt("R6 wrap", 5);
      req = '0; grp_rr = 0; step();
   endtask

   task automatic t_err();
      gprio = 8'b11_10_01_01;
      req = '0; req[3] = 1; step();
      chk("R7 error set", int'(err), 1);
      chk("R7 grant blocked", int'(vld), 0);
      req = '0; step();
      chk("R8 sticky", int'(err), 1);
      eclr = 1; step(); eclr = 0;
      chk("R8 cleared", int'(err), 0);
      step();
      chk("R7 no req no error", int'(err), 0);
      req[3] = 1; step();
      chk("R7 set again", int'(err), 1);
      req = '0; gprio = 8'b11_10_01_00; step();
      chk("R8 fixed config", int'(err), 0);
      req[3] = 1; step();
      chk_gnt("R7 grant after fix", 3);
      chk("R7 error low", int'(err), 0);
      req = '0; step();
   endtask

   task automatic t_single();
      cprio16[7*4 +: 4] = 4'd2; cprio16[11*4 +: 4] = 4'd1;
      req16 = '0; req16[7] = 1; req16[11] = 1; step();
      chk("R8 single group no error", int'(err16), 0);
      chk("R1 16ch valid", int'(vld16), 1);
      chk("R3 16ch channel", int'(ch16), 7);
      req16 = '0; step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fixed();
      t_ch_rr();
      t_grp_rr();
      t_err();
      t_single();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule